// File: doc/BRIEF.md
# Dual Bi-Quinary Ripple Counter

The block holds a configurable number of identical counters (two by default). Each counter has two sections that share nothing but a clear. The first section divides by two and toggles its single output on every falling edge of its own clock input. The second section divides by five and advances a three-bit count on every falling edge of a second, separate clock input. A per-counter clear input that is high forces every output of that counter to zero at once, without waiting for any clock edge.

Because the two sections have separate clocks, wiring outside the block picks the counting code. If the divide-by-two output drives the divide-by-five clock, the four outputs form a BCD decade count. If the top bit of the divide-by-five section drives the divide-by-two clock, the count is bi-quinary and the single bit becomes a square wave at one tenth of the input rate. If the top quinary bit of one decade-wired counter clocks the next decade-wired counter, the pair divides by one hundred.

Top module: `bq_ripple_dual`

## Requirements
- R1: The divide-by-two output `q_two[u]` inverts on each high-to-low transition of `tick_two[u]` while `clr[u]` is low.
- R2: The divide-by-five count `q_five[3u+2:3u]` (bit 3u is least significant) steps 0,1,2,3,4 and back to 0 on each high-to-low transition of `tick_five[u]` while `clr[u]` is low, and never holds a value above 4.
- R3: While `clr[u]` is high, `q_two[u]` and `q_five[3u+2:3u]` are zero at once and stay zero whatever the clock inputs of that counter do.
- R4: A falling edge on `tick_two[u]` leaves `q_five` of counter u unchanged, and a falling edge on `tick_five[u]` leaves `q_two[u]` unchanged.
- R5: A low-to-high transition on either clock input changes no output.
- R6: With `q_two[u]` wired to `tick_five[u]`, after n falling edges on `tick_two[u]` from clear, `{q_five[3u+2:3u], q_two[u]}` equals n mod 10 in binary, and the top bit `q_five[3u+2]` falls on the step from 9 to 0.
- R7: With `q_five[3u+2]` wired to `tick_two[u]`, after n falling edges on `tick_five[u]` from clear, the quinary count equals n mod 5 and `q_two[u]` equals (n div 5) mod 2, a square wave with a period of ten input edges.
- R8: Each counter responds only to its own clock and clear inputs; activity on one counter leaves the outputs of the other unchanged.
- R9: With both counters wired for BCD and `q_five[2]` of counter 0 driving `tick_two[1]`, after n falling edges on `tick_two[0]` from clear, counter 0 shows n mod 10 and counter 1 shows (n div 10) mod 10, so the pair returns to all zeros after 100 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tick_two | input | UNITS | Falling-edge clock of each counter's divide-by-two section |
| tick_five | input | UNITS | Falling-edge clock of each counter's divide-by-five section |
| clr | input | UNITS | Active-high asynchronous clear, one per counter |
| q_two | output | UNITS | Divide-by-two output of each counter |
| q_five | output | 3*UNITS | Divide-by-five count, three bits per counter, counter u in bits 3u+2..3u |

## Verification
The assertions take for granted that every clock input and every clear starts from a defined level at time zero with the clear already high, so that no edge is seen on an unknown value, and that a clear pulse may land between a falling and the next rising clock edge, which is why the step checks re-arm only after a falling edge with the clear low. The bench keeps to this by driving all clears high and all clock lines low in its first statement, and it changes the external wiring between modes only while the clears are high. Its random phase draws falls on either clock of either counter and short clear pulses, and compares every output after each rising and each falling half of a pulse against a model of its own.

// File: rtl/bq_ripple_pkg.sv
package bq_ripple_pkg;

  // Next state of a modulus counter held in up to eight bits.
  function automatic logic [7:0] ring_next(input logic [7:0] cur, input int unsigned modulus);
    logic [7:0] bumped;
    bumped = cur + 8'd1;
    if (int'(bumped) >= int'(modulus))
      return 8'd0;
    return bumped;
  endfunction

  // Bits needed to hold the values 0 .. modulus-1.
  function automatic int unsigned ring_width(input int unsigned modulus);
    int unsigned w;
    w = 1;
    while ((32'd1 << w) < modulus)
      w++;
    return w;
  endfunction

endpackage

// File: rtl/bq_toggle_stage.sv
module bq_toggle_stage (
  input  logic tick,
  input  logic clr,
  output logic q
);

  logic state;

  always_ff @(negedge tick or posedge clr) begin
    if (clr) state <= 1'b0;
    else     state <= ~state;
  end

  assign q = state;

endmodule

// File: rtl/bq_ring_stage.sv
module bq_ring_stage
  import bq_ripple_pkg::*;
#(
  parameter int unsigned MODULUS = 5,
  localparam int unsigned W = ring_width(MODULUS)
) (
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] q
);

  logic [W-1:0] count;
  logic [W-1:0] count_after;

  assign count_after = W'(ring_next(8'(count), MODULUS));

  always_ff @(negedge tick or posedge clr) begin
    if (clr) count <= '0;
    else     count <= count_after;
  end

  assign q = count;

endmodule

// File: rtl/bq_counter_unit.sv
module bq_counter_unit
  import bq_ripple_pkg::*;
#(
  parameter int unsigned FIVE_MOD = 5,
  localparam int unsigned FIVE_W = ring_width(FIVE_MOD)
) (
  input  logic              tick_two,
  input  logic              tick_five,
  input  logic              clr,
  output logic              q_two,
  output logic [FIVE_W-1:0] q_five
);

  bq_toggle_stage u_two (
    .tick (tick_two),
    .clr  (clr),
    .q    (q_two)
  );

  bq_ring_stage #(.MODULUS(FIVE_MOD)) u_five (
    .tick (tick_five),
    .clr  (clr),
    .q    (q_five)
  );

endmodule

// File: rtl/bq_ripple_dual.sv
module bq_ripple_dual
  import bq_ripple_pkg::*;
#(
  parameter int unsigned UNITS    = 2,
  parameter int unsigned FIVE_MOD = 5,
  localparam int unsigned FIVE_W  = ring_width(FIVE_MOD)
) (
  input  logic [UNITS-1:0]        tick_two,
  input  logic [UNITS-1:0]        tick_five,
  input  logic [UNITS-1:0]        clr,
  output logic [UNITS-1:0]        q_two,
  output logic [UNITS*FIVE_W-1:0] q_five
);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    bq_counter_unit #(.FIVE_MOD(FIVE_MOD)) u_cnt (
      .tick_two  (tick_two[u]),
      .tick_five (tick_five[u]),
      .clr       (clr[u]),
      .q_two     (q_two[u]),
      .q_five    (q_five[u*FIVE_W +: FIVE_W])
    );
  end

endmodule

// File: rtl/bq_ripple_dual_chk.sv
module bq_ripple_dual_chk
  import bq_ripple_pkg::*;
#(
  parameter int unsigned UNITS    = 2,
  parameter int unsigned FIVE_MOD = 5,
  localparam int unsigned FW      = ring_width(FIVE_MOD)
) (
  input logic [UNITS-1:0]    tick_two,
  input logic [UNITS-1:0]    tick_five,
  input logic [UNITS-1:0]    clr,
  input logic [UNITS-1:0]    q_two,
  input logic [UNITS*FW-1:0] q_five
);

  for (genvar g = 0; g < UNITS; g++) begin : g_chk
    logic          armed_two;
    logic          prev_two;
    logic          armed_five;
    logic [FW-1:0] prev_five;

    // Snapshot the pre-edge value at each falling edge; a clear disarms.
    always_ff @(negedge tick_two[g] or posedge clr[g]) begin
      if (clr[g]) begin
        armed_two <= 1'b0;
        prev_two  <= 1'b0;
      end else begin
        armed_two <= 1'b1;
        prev_two  <= q_two[g];
      end
    end

    always_ff @(negedge tick_five[g] or posedge clr[g]) begin
      if (clr[g]) begin
        armed_five <= 1'b0;
        prev_five  <= '0;
      end else begin
        armed_five <= 1'b1;
        prev_five  <= q_five[g*FW +: FW];
      end
    end

    assert_two_toggles_R1: assert property (@(posedge tick_two[g]) disable iff (clr[g])
      armed_two |-> (q_two[g] != prev_two));

    assert_five_steps_R2: assert property (@(posedge tick_five[g]) disable iff (clr[g])
      armed_five |-> (q_five[g*FW +: FW] ==
        ((prev_five == FW'(FIVE_MOD - 1)) ? '0 : prev_five + 1'b1)));

    assert_five_in_range_R2: assert property (@(negedge tick_five[g]) disable iff (clr[g])
      (int'(q_five[g*FW +: FW]) < int'(FIVE_MOD)));

    assert_clear_holds_zero_R3: assert property (@(negedge clr[g])
      ((q_two[g] == 1'b0) && (q_five[g*FW +: FW] == '0)));
  end

endmodule

bind bq_ripple_dual bq_ripple_dual_chk #(.UNITS(UNITS), .FIVE_MOD(FIVE_MOD)) u_chk (
  .tick_two  (tick_two),
  .tick_five (tick_five),
  .clr       (clr),
  .q_two     (q_two),
  .q_five    (q_five)
);

// File: tb/bq_ripple_dual_bench.sv
module bq_ripple_dual_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] cka_d;
  logic [1:0] ckb_d;
  logic [1:0] clr_d;
  logic bcd0  = 1'b0;
  logic bcd1  = 1'b0;
  logic biq0  = 1'b0;
  logic chain = 1'b0;

  logic       tick_two0, tick_two1, tick_five0, tick_five1;
  logic [1:0] q_two;
  logic [5:0] q_five;

  assign tick_two0  = biq0  ? q_five[2] : cka_d[0];
  assign tick_five0 = bcd0  ? q_two[0]  : ckb_d[0];
  assign tick_two1  = chain ? q_five[2] : cka_d[1];
  assign tick_five1 = bcd1  ? q_two[1]  : ckb_d[1];

  bq_ripple_dual u_bq_ripple_dual (
    .tick_two  ({tick_two1, tick_two0}),
    .tick_five ({tick_five1, tick_five0}),
    .clr       (clr_d),
    .q_two     (q_two),
    .q_five    (q_five)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;
  int m_two  [2];
  int m_five [2];

  // Expected values, computed from the requirements.
  function automatic int exp_bcd(int n);
    return n % 10;
  endfunction

  function automatic int exp_biq(int n);
    return (((n / 5) % 2) * 8) + (n % 5);
  endfunction

  function automatic int exp_tens(int n);
    return (n / 10) % 10;
  endfunction

  function automatic int unit_val(int u);
    return int'({q_five[u*3 +: 3], q_two[u]});
  endfunction

  task automatic chk(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic chk_model(string req);
    for (int u = 0; u < 2; u++)
      chk(req, unit_val(u), m_five[u] * 2 + m_two[u]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic reconfigure(bit b0, bit b1, bit q0, bit ch);
    @(posedge clk);
    clr_d = 2'b11;
    cka_d = 2'b00;
    ckb_d = 2'b00;
    @(posedge clk);
    bcd0 = b0; bcd1 = b1; biq0 = q0; chain = ch;
    @(posedge clk);
    clr_d = 2'b00;
    for (int u = 0; u < 2; u++) begin
      m_two[u] = 0;
      m_five[u] = 0;
    end
    @(negedge clk);
  endtask

  // One full pulse on a drive line; which=0 selects the two-stage clock.
  task automatic pulse(int u, int which, bit check_rise);
    @(posedge clk);
    if (which == 0) cka_d[u] = 1'b1; else ckb_d[u] = 1'b1;
    @(negedge clk);
    if (check_rise) chk("R5 rising edge", unit_val(u), m_five[u] * 2 + m_two[u]);
    @(posedge clk);
    if (which == 0) cka_d[u] = 1'b0; else ckb_d[u] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    clr_d = 2'b11;
    cka_d = 2'b00;
    ckb_d = 2'b00;
    void'($urandom(32'd4242));
    m_two  = '{0, 0};
    m_five = '{0, 0};

    repeat (2) @(negedge clk);
    chk("R3 reset state unit0", unit_val(0), 0);
    chk("R3 reset state unit1", unit_val(1), 0);

    // Clock edges during clear leave the outputs at zero (R3).
    pulse(0, 0, 1'b0);
    pulse(0, 1, 1'b0);
    pulse(1, 0, 1'b0);
    chk("R3 clocks ignored under clear", unit_val(0) + unit_val(1), 0);

    // Independent sections, directed: five-stage wrap and toggle (R1, R2, R4).
    reconfigure(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i <= 6; i++) begin
      pulse(0, 1, 1'b1);
      m_five[0] = (m_five[0] == 4) ? 0 : m_five[0] + 1;
      chk("R2 five-stage step", int'(q_five[2:0]), i % 5);
      chk("R4 two-stage untouched by five clock", int'(q_two[0]), 0);
    end
    pulse(0, 0, 1'b1);
    m_two[0] = 1;
    chk("R1 toggle high", int'(q_two[0]), 1);
    chk("R4 five-stage untouched by two clock", int'(q_five[2:0]), 1);
    pulse(0, 0, 1'b1);
    m_two[0] = 0;
    chk("R1 toggle low", int'(q_two[0]), 0);
    chk("R8 other unit untouched", unit_val(1), 0);

    // Random mix on both counters in independent mode (R1, R2, R4, R5, R8, R3).
    for (int k = 0; k < 400; k++) begin
      int u;
      int op;
      u  = int'($urandom_range(0, 1));
      op = int'($urandom_range(0, 9));
      if (op <= 3) begin
        pulse(u, 0, 1'b1);
        m_two[u] = 1 - m_two[u];
        chk_model("R1 R4 R8 random two-stage fall");
      end else if (op <= 8) begin
        pulse(u, 1, 1'b1);
        m_five[u] = (m_five[u] + 1) % 5;
        chk_model("R2 R4 R8 random five-stage fall");
      end else begin
        @(posedge clk);
        clr_d[u] = 1'b1;
        @(negedge clk);
        m_two[u] = 0;
        m_five[u] = 0;
        chk_model("R3 random clear");
        @(posedge clk);
        clr_d[u] = 1'b0;
        @(negedge clk);
      end
    end

    // BCD decade wiring on counter 0 (R6).
    reconfigure(1'b1, 1'b0, 1'b0, 1'b0);
    for (int n = 1; n <= 25; n++) begin
      int top_before;
      top_before = int'(q_five[2]);
      pulse(0, 0, 1'b0);
      chk("R6 decade value", unit_val(0), exp_bcd(n));
      if (n % 10 == 0) begin
        chk("R6 top bit high before wrap", top_before, 1);
        chk("R6 top bit low after wrap", int'(q_five[2]), 0);
      end
    end

    // Clear in the middle of a decade count (R3).
    reconfigure(1'b1, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 7; n++) pulse(0, 0, 1'b0);
    chk("R6 decade before clear", unit_val(0), 7);
    @(posedge clk);
    clr_d[0] = 1'b1;
    @(negedge clk);
    chk("R3 mid-count clear", unit_val(0), 0);
    pulse(0, 0, 1'b0);
    chk("R3 clear holds through clock", unit_val(0), 0);
    @(posedge clk);
    clr_d[0] = 1'b0;
    @(negedge clk);
    pulse(0, 0, 1'b0);
    chk("R6 count resumes from zero", unit_val(0), 1);

    // Bi-quinary wiring on counter 0 (R7).
    reconfigure(1'b0, 1'b0, 1'b1, 1'b0);
    for (int n = 1; n <= 23; n++) begin
      pulse(0, 1, 1'b0);
      chk("R7 bi-quinary value", int'({q_two[0], q_five[2:0]}), exp_biq(n));
    end

    // Two decade counters chained: divide by one hundred (R9).
    reconfigure(1'b1, 1'b1, 1'b0, 1'b1);
    for (int n = 1; n <= 120; n++) begin
      pulse(0, 0, 1'b0);
      chk("R9 units digit", unit_val(0), exp_bcd(n));
      chk("R9 tens digit", unit_val(1), exp_tens(n));
    end

    finish_run();
  end

endmodule